// File: doc/BRIEF.md
# Doorbell Mailbox Channel Unit

This block carries short notifications between two agents through a set of 32-bit doorbell channels. The sending agent sees one register frame and the receiving agent sees another; both frames address the same channel flag storage. The sender raises flag bits in a channel by writing ones to it. The receiver reads the flags, hides selected bits behind a per-channel mask, and clears the bits it has serviced. A level interrupt to the receiver stays high while any channel holds a flag bit that its mask leaves visible.

Before the sender may touch the channels it must raise an access request and wait for an access-ready indication, which follows the request after a short wake-up delay. Set writes issued while ready is low are dropped. Each frame also reports how many channels are built and an architecture identification word. Each side uses a simple single-cycle register bus: a write strobe with address and data, and read data that follows the address combinationally.

Top module: `dbell_mbox`

## Requirements
- R1: After reset every flag bit and every mask bit is 0, the access request reads 0 at sender offset 0xF88, ready reads 0 at sender offset 0xF8C, and the interrupt is low.
- R2: Channel n occupies the 0x20-byte window at n*0x20 in each frame. A sender write to window offset 0x0C while ready is high ORs the written ones into that channel's flags, which read back at sender offset 0x00 and receiver offset 0x00 from the next cycle.
- R3: A receiver write to window offset 0x08 clears the flag bits where the written value has ones; writing all ones empties the channel.
- R4: Receiver offset 0x14 ORs ones into the channel mask, offset 0x18 clears mask bits where the value has ones, offset 0x10 reads the mask, and offset 0x04 reads the flags with masked bits forced to 0.
- R5: The interrupt is high exactly when some channel has a flag bit set whose mask bit is 0.
- R6: Bit 0 of sender offset 0xF88 is a read/write access request. Ready (bit 0 of 0xF8C) reads 1 from the second clock edge after the edge that writes the request to 1, and reads 0 from the edge that writes the request to 0.
- R7: Sender set writes issued while ready is low leave all flags unchanged.
- R8: When a sender set and a receiver clear hit the same flag bit in the same cycle, the bit ends up set.
- R9: Offset 0xF80 in both frames reads the number of channels (4 by default); offset 0xFCC in both frames reads the architecture word with major revision 0x1 in bits 7:4 and minor revision in bits 3:0 (0x11 by default).
- R10: Undefined offsets, including windows beyond the last channel, read as 0, and writes to read-only or undefined offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| snd_wr | input | 1 | Sender frame write strobe |
| snd_addr | input | 12 | Sender frame byte address |
| snd_wdata | input | 32 | Sender frame write data |
| snd_rdata | output | 32 | Sender frame read data for snd_addr |
| rcv_wr | input | 1 | Receiver frame write strobe |
| rcv_addr | input | 12 | Receiver frame byte address |
| rcv_wdata | input | 32 | Receiver frame write data |
| rcv_rdata | output | 32 | Receiver frame read data for rcv_addr |
| rcv_irq | output | 1 | Level interrupt for pending unmasked flags |

## Verification
The assertions take for granted that each write strobe lasts one clock edge per access and that address and data are known whenever a strobe is high, so the sampled write value is the one the design committed. The priority and clear properties also assume a single write per side per cycle, with mask set and mask clear never arriving together because they share one bus. The bench drives all inputs on the falling edge, drops each strobe right after the committing rising edge, and never overlaps two accesses on one side, so the stimulus stays inside these assumptions.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int unsigned FRAME_AW  = 12;
  localparam int unsigned WIN_SHIFT = 5;
  localparam int unsigned IDX_W     = FRAME_AW - WIN_SHIFT;

  // window offsets
  localparam logic [WIN_SHIFT-1:0] OFF_FLAGS   = 5'h00;
  localparam logic [WIN_SHIFT-1:0] OFF_VISIBLE = 5'h04;
  localparam logic [WIN_SHIFT-1:0] OFF_CLEAR   = 5'h08;
  localparam logic [WIN_SHIFT-1:0] OFF_RAISE   = 5'h0C;
  localparam logic [WIN_SHIFT-1:0] OFF_MASK    = 5'h10;
  localparam logic [WIN_SHIFT-1:0] OFF_MASKON  = 5'h14;
  localparam logic [WIN_SHIFT-1:0] OFF_MASKOFF = 5'h18;

  // frame-level addresses
  localparam logic [FRAME_AW-1:0] ADR_WIN_END = 12'hF80;
  localparam logic [FRAME_AW-1:0] ADR_COUNT   = 12'hF80;
  localparam logic [FRAME_AW-1:0] ADR_WAKEREQ = 12'hF88;
  localparam logic [FRAME_AW-1:0] ADR_WAKEACK = 12'hF8C;
  localparam logic [FRAME_AW-1:0] ADR_ARCHID  = 12'hFCC;

  localparam logic [3:0] ARCH_MAJOR = 4'h1;

  // set wins over clear on a shared bit
  function automatic logic [31:0] flag_next(input logic [31:0] cur,
                                            input logic [31:0] raise,
                                            input logic [31:0] drop);
    return (cur & ~drop) | raise;
  endfunction

  function automatic logic [31:0] mask_next(input logic [31:0] cur,
                                            input logic [31:0] on,
                                            input logic [31:0] off);
    return (cur | on) & ~off;
  endfunction

  function automatic logic [31:0] visible_bits(input logic [31:0] flags,
                                               input logic [31:0] mask);
    return flags & ~mask;
  endfunction

  function automatic logic [31:0] arch_word(input logic [3:0] minor);
    return {24'h0, ARCH_MAJOR, minor};
  endfunction
endpackage

// File: rtl/dbell_win_dec.sv
module dbell_win_dec
  import dbell_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic [FRAME_AW-1:0]  addr,
  output logic [NUM_CH-1:0]    hit,
  output logic [WIN_SHIFT-1:0] off
);
  logic             in_windows;
  logic [IDX_W-1:0] idx;

  assign in_windows = addr < ADR_WIN_END;
  assign idx        = addr[FRAME_AW-1:WIN_SHIFT];
  assign off        = addr[WIN_SHIFT-1:0];

  for (genvar n = 0; n < NUM_CH; n++) begin : g_hit
    assign hit[n] = in_windows && (idx == IDX_W'(n));
  end
endmodule

// File: rtl/dbell_access.sv
module dbell_access #(
  parameter int unsigned WAKE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_wr,
  input  logic req_val,
  output logic req,
  output logic ready
);
  localparam int unsigned CW = $clog2(WAKE_CYCLES + 1);

  logic [CW-1:0] wait_cnt;
  logic          wait_done;

  assign wait_done = wait_cnt == CW'(WAKE_CYCLES);
  assign ready     = req && wait_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req      <= 1'b0;
      wait_cnt <= '0;
    end else begin
      if (req_wr) req <= req_val;
      if (!req) wait_cnt <= '0;
      else if (!wait_done) wait_cnt <= wait_cnt + 1'b1;
    end
  end

  // R6: ready only rises after request has been held for the wake-up delay
  p_ready_waits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(req) && $past(req, 2)));

  // R6: dropping the request drops ready at once
  p_ready_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && !req_val) |=> !ready);
endmodule

// File: rtl/dbell_chan.sv
module dbell_chan
  import dbell_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raise_en,
  input  logic [DATA_W-1:0] raise_val,
  input  logic              clear_en,
  input  logic              mask_on_en,
  input  logic              mask_off_en,
  input  logic [DATA_W-1:0] rcv_val,
  output logic [DATA_W-1:0] flags,
  output logic [DATA_W-1:0] mask,
  output logic              pending
);
  logic [DATA_W-1:0] raise_bits, drop_bits, on_bits, off_bits;

  assign raise_bits = raise_en    ? raise_val : '0;
  assign drop_bits  = clear_en    ? rcv_val   : '0;
  assign on_bits    = mask_on_en  ? rcv_val   : '0;
  assign off_bits   = mask_off_en ? rcv_val   : '0;
  assign pending    = |visible_bits(flags, mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
    end else begin
      flags <= flag_next(flags, raise_bits, drop_bits);
      mask  <= mask_next(mask, on_bits, off_bits);
    end
  end

  // R2: every raised bit is present after the edge
  p_raise_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    raise_en |=> ((flags & $past(raise_val)) == $past(raise_val)));

  // R3: cleared bits are gone when nothing is raised at the same time
  p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_en && !raise_en) |=> ((flags & $past(rcv_val)) == '0));

  // R4: mask set bits stick
  p_mask_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_on_en && !mask_off_en) |=> ((mask & $past(rcv_val)) == $past(rcv_val)));

  // R8: a bit both raised and cleared stays raised
  p_raise_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_en && clear_en) |=>
      ((flags & $past(raise_val & rcv_val)) == $past(raise_val & rcv_val)));
endmodule

// File: rtl/dbell_mbox.sv
module dbell_mbox
  import dbell_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned WAKE_CYCLES = 2,
  parameter int unsigned ARCH_MINOR  = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                snd_wr,
  input  logic [FRAME_AW-1:0] snd_addr,
  input  logic [DATA_W-1:0]   snd_wdata,
  output logic [DATA_W-1:0]   snd_rdata,
  input  logic                rcv_wr,
  input  logic [FRAME_AW-1:0] rcv_addr,
  input  logic [DATA_W-1:0]   rcv_wdata,
  output logic [DATA_W-1:0]   rcv_rdata,
  output logic                rcv_irq
);
  localparam logic [DATA_W-1:0] COUNT_WORD = DATA_W'(NUM_CH);
  localparam logic [DATA_W-1:0] ARCH_WORD  = DATA_W'(arch_word(4'(ARCH_MINOR)));

  logic [NUM_CH-1:0]    snd_hit, rcv_hit, pend;
  logic [WIN_SHIFT-1:0] snd_off, rcv_off;
  logic                 wake_req, wake_ack;
  logic [DATA_W-1:0]    flags [NUM_CH];
  logic [DATA_W-1:0]    mask  [NUM_CH];
  logic [NUM_CH*DATA_W-1:0] flags_flat;
  logic                 raise_try;

  dbell_win_dec #(.NUM_CH(NUM_CH)) u_snd_dec (
    .addr(snd_addr), .hit(snd_hit), .off(snd_off));
  dbell_win_dec #(.NUM_CH(NUM_CH)) u_rcv_dec (
    .addr(rcv_addr), .hit(rcv_hit), .off(rcv_off));

  dbell_access #(.WAKE_CYCLES(WAKE_CYCLES)) u_access (
    .clk(clk), .rst_n(rst_n),
    .req_wr(snd_wr && (snd_addr == ADR_WAKEREQ)),
    .req_val(snd_wdata[0]),
    .req(wake_req), .ready(wake_ack));

  assign raise_try = snd_wr && (|snd_hit) && (snd_off == OFF_RAISE);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    dbell_chan #(.DATA_W(DATA_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .raise_en(raise_try && snd_hit[n] && wake_ack),
      .raise_val(snd_wdata),
      .clear_en(rcv_wr && rcv_hit[n] && (rcv_off == OFF_CLEAR)),
      .mask_on_en(rcv_wr && rcv_hit[n] && (rcv_off == OFF_MASKON)),
      .mask_off_en(rcv_wr && rcv_hit[n] && (rcv_off == OFF_MASKOFF)),
      .rcv_val(rcv_wdata),
      .flags(flags[n]), .mask(mask[n]), .pending(pend[n]));
    assign flags_flat[n*DATA_W +: DATA_W] = flags[n];
  end

  assign rcv_irq = |pend;

  always_comb begin
    snd_rdata = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (snd_hit[n] && snd_off == OFF_FLAGS) snd_rdata = flags[n];
    end
    case (snd_addr)
      ADR_COUNT:   snd_rdata = COUNT_WORD;
      ADR_WAKEREQ: snd_rdata = DATA_W'(wake_req);
      ADR_WAKEACK: snd_rdata = DATA_W'(wake_ack);
      ADR_ARCHID:  snd_rdata = ARCH_WORD;
      default: ;
    endcase
  end

  always_comb begin
    rcv_rdata = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (rcv_hit[n]) begin
        case (rcv_off)
          OFF_FLAGS:   rcv_rdata = flags[n];
          OFF_VISIBLE: rcv_rdata = visible_bits(flags[n], mask[n]);
          OFF_MASK:    rcv_rdata = mask[n];
          default: ;
        endcase
      end
    end
    case (rcv_addr)
      ADR_COUNT:  rcv_rdata = COUNT_WORD;
      ADR_ARCHID: rcv_rdata = ARCH_WORD;
      default: ;
    endcase
  end

  // R7: a raise attempted without ready leaves every flag as it was
  p_blocked_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_try && !wake_ack && !rcv_wr) |=> $stable(flags_flat));

  // R5: interrupt never high with all flags empty
  p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_irq |-> (flags_flat != '0));
endmodule

// File: tb/sim_dbell_mbox.sv
module sim_dbell_mbox;
  localparam int CLK_PER = 10;
  localparam int NCH     = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        snd_wr = 1'b0, rcv_wr = 1'b0;
  logic [11:0] snd_addr = '0, rcv_addr = '0;
  logic [31:0] snd_wdata = '0, rcv_wdata = '0;
  logic [31:0] snd_rdata, rcv_rdata;
  logic        rcv_irq;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  int          side_q[$];
  logic [31:0] exp_q[$];
  string       msg_q[$];

  dbell_mbox #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .snd_wr(snd_wr), .snd_addr(snd_addr), .snd_wdata(snd_wdata), .snd_rdata(snd_rdata),
    .rcv_wr(rcv_wr), .rcv_addr(rcv_addr), .rcv_wdata(rcv_wdata), .rcv_rdata(rcv_rdata),
    .rcv_irq(rcv_irq));

  always #(CLK_PER/2) clk = ~clk;

  // driver tasks: each starts on a falling edge
  task automatic snd_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); snd_wr = 1'b1; snd_addr = a; snd_wdata = d;
    @(posedge clk); #1 snd_wr = 1'b0;
  endtask

  task automatic rcv_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); rcv_wr = 1'b1; rcv_addr = a; rcv_wdata = d;
    @(posedge clk); #1 rcv_wr = 1'b0;
  endtask

  task automatic both_write(input logic [11:0] sa, input logic [31:0] sd,
                            input logic [11:0] ra, input logic [31:0] rd);
    @(negedge clk);
    snd_wr = 1'b1; snd_addr = sa; snd_wdata = sd;
    rcv_wr = 1'b1; rcv_addr = ra; rcv_wdata = rd;
    @(posedge clk); #1 snd_wr = 1'b0; rcv_wr = 1'b0;
  endtask

  // side 0 = sender read, 1 = receiver read, 2 = interrupt
  task automatic expect_rd(input int side, input logic [11:0] a,
                           input logic [31:0] e, input string m);
    @(negedge clk);
    if (side == 0) snd_addr = a;
    else if (side == 1) rcv_addr = a;
    side_q.push_back(side); exp_q.push_back(e); msg_q.push_back(m);
  endtask

  // monitor: compares a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk); #(CLK_PER/4);
      while (side_q.size() > 0) begin
        int s; logic [31:0] e, got; string m;
        s = side_q.pop_front(); e = exp_q.pop_front(); m = msg_q.pop_front();
        got = (s == 0) ? snd_rdata : (s == 1) ? rcv_rdata : {31'h0, rcv_irq};
        checks++;
        if (got !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", m, got, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_rd(0, 12'h000, 32'h0, "R1 sender flags ch0");
    expect_rd(1, 12'h070, 32'h0, "R1 mask ch3");
    expect_rd(0, 12'hF88, 32'h0, "R1 request");
    expect_rd(0, 12'hF8C, 32'h0, "R1 ready");
    expect_rd(2, 12'h000, 32'h0, "R1 irq");

    // R9 identification
    expect_rd(0, 12'hF80, 32'd4, "R9 sender count");
    expect_rd(1, 12'hF80, 32'd4, "R9 receiver count");
    expect_rd(0, 12'hFCC, 32'h11, "R9 sender arch");
    expect_rd(1, 12'hFCC, 32'h11, "R9 receiver arch");

    // R7 set without ready is dropped
    snd_write(12'h00C, 32'hFF);
    expect_rd(1, 12'h000, 32'h0, "R7 blocked raise ch0");

    // R6 wake-up handshake
    snd_write(12'hF88, 32'h1);
    expect_rd(0, 12'hF8C, 32'h0, "R6 ready after 1 edge");
    expect_rd(0, 12'hF8C, 32'h0, "R6 ready after 2 edges");
    expect_rd(0, 12'hF8C, 32'h1, "R6 ready after 3 edges");
    expect_rd(0, 12'hF88, 32'h1, "R6 request readback");

    // R2 raise and OR-accumulate on ch1
    snd_write(12'h02C, 32'hA5);
    expect_rd(0, 12'h020, 32'hA5, "R2 sender view ch1");
    expect_rd(1, 12'h020, 32'hA5, "R2 receiver view ch1");
    expect_rd(2, 12'h000, 32'h1, "R5 irq unmasked flag");
    snd_write(12'h02C, 32'h100);
    expect_rd(1, 12'h020, 32'h1A5, "R2 OR accumulate");

    // R4 mask handling
    rcv_write(12'h034, 32'h1A5);
    expect_rd(1, 12'h030, 32'h1A5, "R4 mask status");
    expect_rd(1, 12'h024, 32'h0, "R4 visible all masked");
    expect_rd(2, 12'h000, 32'h0, "R5 irq all masked");
    rcv_write(12'h038, 32'h100);
    expect_rd(1, 12'h030, 32'hA5, "R4 mask clear");
    expect_rd(1, 12'h024, 32'h100, "R4 visible partial");
    expect_rd(2, 12'h000, 32'h1, "R5 irq partial");

    // R3 clearing
    rcv_write(12'h028, 32'h100);
    expect_rd(1, 12'h020, 32'hA5, "R3 partial clear");
    expect_rd(2, 12'h000, 32'h0, "R5 irq only masked left");
    rcv_write(12'h028, 32'hFFFF_FFFF);
    expect_rd(0, 12'h020, 32'h0, "R3 clear all");

    // R8 set beats clear on ch2
    snd_write(12'h04C, 32'h4);
    both_write(12'h04C, 32'h3, 12'h048, 32'h6);
    expect_rd(1, 12'h040, 32'h3, "R8 set over clear");

    // R10 reserved and read-only locations
    expect_rd(1, 12'h04C, 32'h0, "R10 reserved window offset");
    expect_rd(0, 12'h044, 32'h0, "R10 sender reserved offset");
    expect_rd(1, 12'h080, 32'h0, "R10 window past last channel");
    expect_rd(0, 12'hF90, 32'h0, "R10 reserved frame offset");
    snd_write(12'h040, 32'hFFFF);
    expect_rd(0, 12'h040, 32'h3, "R10 write to status ignored");
    rcv_write(12'hF80, 32'h55);
    expect_rd(1, 12'hF80, 32'd4, "R10 write to count ignored");
    snd_write(12'h08C, 32'hFF);
    expect_rd(1, 12'h000, 32'h0, "R10 raise past last channel ch0");
    expect_rd(1, 12'h060, 32'h0, "R10 raise past last channel ch3");

    // R6 drop and R7 again
    snd_write(12'hF88, 32'h0);
    expect_rd(0, 12'hF8C, 32'h0, "R6 ready drops");
    snd_write(12'h06C, 32'h1);
    expect_rd(1, 12'h060, 32'h0, "R7 blocked after drop");

    // last channel after re-request
    snd_write(12'hF88, 32'h1);
    repeat (3) @(negedge clk);
    snd_write(12'h06C, 32'h8000_0000);
    expect_rd(1, 12'h060, 32'h8000_0000, "R2 last channel");
    rcv_write(12'h048, 32'hFFFF_FFFF);
    expect_rd(2, 12'h000, 32'h1, "R5 irq from last channel");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule